// File: doc/BRIEF.md
# Cascaded Interrupt Aggregator

This block collects up to sixteen level-sensitive interrupt sources from board logic. It presents them to a host processor as one combined interrupt line. Each source has three state bits: an arm (enable) bit, which decides whether the source can latch as pending; a pending bit, which holds the latched request until software acknowledges it; and an allow (unmask) bit, which decides whether a pending request reaches the combined line.

Software reaches the block over a simple memory-mapped register bus. Each register holds 16 data bits and sits on its own 32-bit word. Arm and allow bits are changed only through separate write-one-to-set and write-one-to-clear registers, so no read-modify-write is needed. A pending bit is cleared by writing a one to it.

A handler reads the pending register and services the lowest-numbered set bit first. Bit 0 belongs to the first cascaded interrupt number. Masking and acknowledging a source may be issued as two back-to-back writes.

Top module: `irq_cascade_agg`

## Requirements
- R1: After a synchronous reset, all arm, allow and pending bits are 0. The combined output `irq_out` is low, and every register reads as zero.
- R2: Registers sit at byte offsets 0x00 (pending), 0x04 (allow-set), 0x08 (allow-clear), 0x0C (arm-set) and 0x10 (arm-clear). A read captures data in the clock edge where `bus_rd` is high, and `bus_rdata` shows it until the next edge. Bits 31:16 of `bus_rdata` are always zero. Any other offset reads as zero and ignores writes, and that includes offsets whose two low bits are not 0. When `bus_rd` is low, `bus_rdata` is zero.
- R3: Writing to 0x0C sets every arm bit whose data bit is 1 and leaves the other arm bits unchanged. Reads of 0x0C and 0x10 return the arm bits.
- R4: Writing to 0x10 clears every arm bit whose data bit is 1 and leaves the other arm bits unchanged.
- R5: Writing to 0x04 sets (unmasks) every allow bit written as 1. Writing to 0x08 clears (masks) every allow bit written as 1. Bits written as 0 are unchanged in both cases. Reads of 0x04 and 0x08 return the allow bits.
- R6: On a clock edge where a source input is high and its arm bit is 1, the source's pending bit becomes 1. The pending bit stays at 1 after the source goes low.
- R7: Writing to 0x00 clears every pending bit written as 1, unless R8 applies. Pending bits written as 0 are unchanged.
- R8: If a source is high and armed in the same cycle as its acknowledge, its pending bit stays set.
- R9: A disarmed source never sets its pending bit. A pending bit that is already set stays set after disarming until it is acknowledged.
- R10: `irq_out` is registered. It is high in the cycle after one where some bit is both pending and allowed, and low otherwise.
- R11: A mask write followed at once by an acknowledge write of the same bit leaves that bit not pending, and `irq_out` low, after the second write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_lvl | input | 16 | Level-sensitive source inputs, bit 0 first |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Combined interrupt to the host |

## Verification
Directed sequences check each register pair separately. Mixed one and zero write patterns show that a set or clear register touches only the bits written as one. A source held high during its own acknowledge separates set-priority from a plain clear. Holding a source high after it is disarmed shows that the old pending bit is kept but no new request latches. A single-cycle source pulse with all bits allowed pins the one-cycle delay of the combined line. Random mixes of writes, reads, misaligned and undefined offsets, and sparse source patterns are then compared every cycle with a bench model of the pending, allow and arm bits.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int NSRC   = 16;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 6;

    typedef enum logic [2:0] {
        SEL_PEND      = 3'd0,
        SEL_ALLOW_SET = 3'd1,
        SEL_ALLOW_CLR = 3'd2,
        SEL_ARM_SET   = 3'd3,
        SEL_ARM_CLR   = 3'd4,
        SEL_NONE      = 3'd7
    } reg_sel_e;

    // Word-aligned offsets map to a register; anything else is undefined.
    function automatic reg_sel_e decode_offset(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        s = SEL_NONE;
        if (a[1:0] == 2'b00) begin
            case (a[ADDR_W-1:2])
                4'd0:    s = SEL_PEND;
                4'd1:    s = SEL_ALLOW_SET;
                4'd2:    s = SEL_ALLOW_CLR;
                4'd3:    s = SEL_ARM_SET;
                4'd4:    s = SEL_ARM_CLR;
                default: s = SEL_NONE;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
    import irq_agg_pkg::*;
#(
    parameter int N  = NSRC,
    parameter int AW = ADDR_W
) (
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [N-1:0]  wdata,
    output reg_sel_e      sel,
    output logic [N-1:0]  ack,
    output logic [N-1:0]  allow_set,
    output logic [N-1:0]  allow_clr,
    output logic [N-1:0]  arm_set,
    output logic [N-1:0]  arm_clr
);
    always_comb begin
        sel       = decode_offset(addr);
        ack       = '0;
        allow_set = '0;
        allow_clr = '0;
        arm_set   = '0;
        arm_clr   = '0;
        if (wr) begin
            case (sel)
                SEL_PEND:      ack       = wdata;
                SEL_ALLOW_SET: allow_set = wdata;
                SEL_ALLOW_CLR: allow_clr = wdata;
                SEL_ARM_SET:   arm_set   = wdata;
                SEL_ARM_CLR:   arm_clr   = wdata;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/irq_src_cell.sv
module irq_src_cell (
    input  logic clk,
    input  logic rst,
    input  logic src,
    input  logic ack,
    input  logic allow_set,
    input  logic allow_clr,
    input  logic arm_set,
    input  logic arm_clr,
    output logic pend,
    output logic allow,
    output logic arm
);
    logic req;
    assign req = src & arm;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend  <= 1'b0;
            allow <= 1'b0;
            arm   <= 1'b0;
        end else begin
            pend  <= req | (pend & ~ack);
            allow <= (allow | allow_set) & ~allow_clr;
            arm   <= (arm | arm_set) & ~arm_clr;
        end
    end

    assert_req_latches_R6: assert property (@(posedge clk) disable iff (rst)
        (src && arm) |=> pend);
    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (ack && !(src && arm)) |=> !pend);
    assert_held_until_ack_R9: assert property (@(posedge clk) disable iff (rst)
        (pend && !ack) |=> pend);
    assert_disarmed_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (!pend && !arm && !arm_set) |=> !pend);
    assert_unmask_R5: assert property (@(posedge clk) disable iff (rst)
        allow_set |=> allow);
    assert_mask_R5: assert property (@(posedge clk) disable iff (rst)
        allow_clr |=> !allow);
endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pend,
    input  logic [N-1:0] allow,
    output logic         irq
);
    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= |(pend & allow);
    end

    assert_irq_rise_R10: assert property (@(posedge clk) disable iff (rst)
        (|(pend & allow)) |=> irq);
    assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !(|(pend & allow)) |=> !irq);
endmodule

// File: rtl/irq_read_port.sv
module irq_read_port
    import irq_agg_pkg::*;
#(
    parameter int N  = NSRC,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd,
    input  reg_sel_e      sel,
    input  logic [N-1:0]  pend,
    input  logic [N-1:0]  allow,
    input  logic [N-1:0]  arm,
    output logic [DW-1:0] rdata
);
    logic [N-1:0] view;

    always_comb begin
        case (sel)
            SEL_PEND:                     view = pend;
            SEL_ALLOW_SET, SEL_ALLOW_CLR: view = allow;
            SEL_ARM_SET, SEL_ARM_CLR:     view = arm;
            default:                      view = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (rd) rdata <= {{(DW-N){1'b0}}, view};
        else         rdata <= '0;
    end

    assert_pend_readback_R2: assert property (@(posedge clk) disable iff (rst)
        (rd && sel == SEL_PEND) |=> rdata[N-1:0] == $past(pend));
    assert_idle_zero_R2: assert property (@(posedge clk) disable iff (rst)
        !rd |=> rdata == '0);
endmodule

// File: rtl/irq_cascade_agg.sv
module irq_cascade_agg
    import irq_agg_pkg::*;
#(
    parameter int N  = NSRC,
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  src_lvl,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [N-1:0]  bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq_out
);
    reg_sel_e     sel;
    logic [N-1:0] ack, allow_set, allow_clr, arm_set, arm_clr;
    logic [N-1:0] pend, allow, arm;

    irq_bus_decode #(.N(N), .AW(AW)) u_dec (
        .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata), .sel(sel),
        .ack(ack), .allow_set(allow_set), .allow_clr(allow_clr),
        .arm_set(arm_set), .arm_clr(arm_clr)
    );

    for (genvar i = 0; i < N; i++) begin : g_cell
        irq_src_cell u_cell (
            .clk(clk), .rst(rst), .src(src_lvl[i]), .ack(ack[i]),
            .allow_set(allow_set[i]), .allow_clr(allow_clr[i]),
            .arm_set(arm_set[i]), .arm_clr(arm_clr[i]),
            .pend(pend[i]), .allow(allow[i]), .arm(arm[i])
        );
    end

    irq_combine #(.N(N)) u_comb (
        .clk(clk), .rst(rst), .pend(pend), .allow(allow), .irq(irq_out)
    );

    irq_read_port #(.N(N), .DW(DW)) u_rd (
        .clk(clk), .rst(rst), .rd(bus_rd), .sel(sel), .pend(pend),
        .allow(allow), .arm(arm), .rdata(bus_rdata)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (!irq_out && bus_rdata == '0));
endmodule

// File: tb/test_irq_cascade_agg.sv
module test_irq_cascade_agg;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] src_lvl = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int n_test = 0, n_fail = 0;
    bit done = 0;

    logic [15:0] m_pend = '0, m_allow = '0, m_arm = '0;
    logic        m_irq = 1'b0;
    logic [31:0] m_rdata = '0;
    logic [31:0] last_rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_cascade_agg i_irq_cascade_agg (
        .clk(clk), .rst(rst), .src_lvl(src_lvl), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    function automatic logic [15:0] view(input logic [5:0] a);
        if (a[1:0] != 2'b00) return 16'h0;
        case (a[5:2])
            4'd0: return m_pend;
            4'd1, 4'd2: return m_allow;
            4'd3, 4'd4: return m_arm;
            default: return 16'h0;
        endcase
    endfunction

    function automatic logic [15:0] wmask(input logic [5:0] a, input logic [3:0] idx);
        return (bus_wr && a[1:0] == 2'b00 && a[5:2] == idx) ? bus_wdata : 16'h0;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_test++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock: update the model from the spec, then compare at the falling edge.
    task automatic tick();
        logic rd_now;
        @(posedge clk);
        rd_now = bus_rd;
        if (rst) begin
            m_pend = '0; m_allow = '0; m_arm = '0; m_irq = 0; m_rdata = '0;
        end else begin
            m_rdata = bus_rd ? {16'h0, view(bus_addr)} : 32'h0;
            m_irq   = |(m_pend & m_allow);
            m_pend  = (src_lvl & m_arm) | (m_pend & ~wmask(bus_addr, 4'd0));
            m_allow = (m_allow | wmask(bus_addr, 4'd1)) & ~wmask(bus_addr, 4'd2);
            m_arm   = (m_arm | wmask(bus_addr, 4'd3)) & ~wmask(bus_addr, 4'd4);
        end
        @(negedge clk);
        chk("R10 model irq", {31'h0, irq_out}, {31'h0, m_irq});
        if (rd_now) chk("R2 model readback", bus_rdata, m_rdata);
        last_rd = bus_rdata;
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 0;
    endtask

    task automatic rd(input logic [5:0] a);
        bus_rd = 1; bus_addr = a;
        tick();
        bus_rd = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_test++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_test, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        rst = 1; tick(); tick(); tick();
        rst = 0;
        chk("R1 irq after reset", {31'h0, irq_out}, 32'h0);
        for (int k = 0; k < 5; k++) begin
            rd(6'(k * 4)); chk("R1 register zero", last_rd, 32'h0);
        end
        // R3 arm-set
        wr(6'h0C, 16'h00F0); rd(6'h0C); chk("R3 arm set", last_rd, 32'h00F0);
        wr(6'h0C, 16'h0003); rd(6'h0C); chk("R3 zeros unchanged", last_rd, 32'h00F3);
        rd(6'h10); chk("R3 arm via clr offset", last_rd, 32'h00F3);
        // R4 arm-clear
        wr(6'h10, 16'h0010); rd(6'h0C); chk("R4 arm clear", last_rd, 32'h00E3);
        // R5 allow
        wr(6'h04, 16'h0081); rd(6'h04); chk("R5 allow set", last_rd, 32'h0081);
        wr(6'h08, 16'h0001); rd(6'h08); chk("R5 allow clear", last_rd, 32'h0080);
        // R6 latch
        src_lvl = 16'h0082; tick(); src_lvl = 16'h0;
        rd(6'h00); chk("R6 pending latched", last_rd, 32'h0082);
        chk("R10 irq high", {31'h0, irq_out}, 32'h1);
        // R8 set beats ack
        src_lvl = 16'h0002; wr(6'h00, 16'h0002); src_lvl = 16'h0;
        rd(6'h00); chk("R8 set wins", last_rd, 32'h0082);
        // R7 ack
        wr(6'h00, 16'h0002); rd(6'h00); chk("R7 ack clears", last_rd, 32'h0080);
        // R11 mask then ack
        wr(6'h08, 16'h0080); wr(6'h00, 16'h0080);
        chk("R11 irq low", {31'h0, irq_out}, 32'h0);
        rd(6'h00); chk("R11 not pending", last_rd, 32'h0);
        // R9 disarm keeps pending
        wr(6'h0C, 16'h0004); src_lvl = 16'h0004; tick();
        wr(6'h10, 16'h0004); tick(); tick();
        rd(6'h00); chk("R9 kept pending", last_rd, 32'h0004);
        wr(6'h00, 16'h0004); rd(6'h00); chk("R9 no relatch", last_rd, 32'h0);
        src_lvl = 16'h0;
        // R2 map edges
        rd(6'h18); chk("R2 undefined offset", last_rd, 32'h0);
        rd(6'h3C); chk("R2 top offset", last_rd, 32'h0);
        wr(6'h05, 16'h0040); rd(6'h04); chk("R2 misaligned write ignored", last_rd, 32'h0);
        wr(6'h04, 16'hFFFF); rd(6'h06); chk("R2 misaligned read", last_rd, 32'h0);
        rd(6'h04); chk("R2 upper half zero", last_rd, 32'h0000FFFF);
        // R10 timing with a one-cycle pulse
        wr(6'h0C, 16'h0008); src_lvl = 16'h0008; tick(); src_lvl = 16'h0;
        chk("R10 not yet", {31'h0, irq_out}, 32'h0);
        tick(); chk("R10 one cycle later", {31'h0, irq_out}, 32'h1);
        wr(6'h00, 16'h0008); tick();
        chk("R10 low after ack", {31'h0, irq_out}, 32'h0);
        // random mix
        void'($urandom(32'h5EED));
        for (int n = 0; n < 2000; n++) begin
            int r;
            r = $urandom_range(0, 9);
            src_lvl = ($urandom_range(0, 3) == 0) ? 16'($urandom) & 16'($urandom) : 16'h0;
            bus_addr = ($urandom_range(0, 7) == 0) ? 6'($urandom) : 6'($urandom_range(0, 5) * 4);
            bus_wdata = 16'($urandom);
            bus_wr = (r < 3);
            bus_rd = (r >= 5);
            tick();
        end
        bus_wr = 0; bus_rd = 0; src_lvl = 0;
        tick();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_test, n_fail);
        $finish;
    end
endmodule